// File: doc/BRIEF.md
# Background Block-Store Engine

This block sits beside a core's memory unit and takes over long block fills. A fill request carries a start address, a word count and a word value. The core gets a small buffer handle back in the same cycle and can write it to its destination register. The engine then writes the words one at a time, without further help from the core, while the core keeps issuing and retiring unrelated instructions.

The engine holds several independent buffers. It steps aside whenever the shared memory port is busy with foreground traffic, and it ignores interrupts. The core can read the progress of any buffer or cancel it by handle. Each buffer drives a hazard flag while it still has stores outstanding, so the issue logic can hold back instructions that depend on the fill. The memory sink is a single-cycle write port: a store presented while the port is idle is committed at that clock edge.

Top module: `bgs_engine`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_handle` names the lowest-numbered free buffer, and that buffer is the one loaded. When no buffer is free, `req_ready` is low and the request is not taken.
- R2: A store (`mem_we` high) is presented only in a cycle with `mem_busy` low. An accepted non-empty request presents its first store in the cycle right after the accepting edge, provided memory is idle then.
- R3: A request for N words writes `req_value` to the N consecutive addresses from `req_base` upward, in increasing order, one store per committed cycle. It writes exactly N words and never touches `req_base+N`.
- R4: When several buffers have stores pending, at most one store is issued per cycle, and the buffers are served round-robin in increasing handle order after the buffer served last. After reset, buffer 0 is served first.
- R5: A cancel (`cxl_valid`, `cxl_handle`) of a running buffer stops it. The store presented in the cancel cycle still commits, no further stores follow, and the status becomes cancelled. A cancel of a buffer that is not running has no effect.
- R6: When the cancel cycle carries the buffer's final store, that store commits and the status reads done, not cancelled.
- R7: `qry_status` shows the state of buffer `qry_handle` in the same cycle, with the codes 0 free, 1 running, 2 done, 3 cancelled.
- R8: A query at a clock edge frees a buffer that is done or cancelled, and the next query of it reads free. A query of a running buffer leaves it running.
- R9: The `irq` input has no effect on any buffer: stores, their order and the final status are the same whether it toggles or not.
- R10: `hazard[i]` is high exactly while buffer i is running. It rises on the edge after acceptance and falls on the edge that commits the last store or takes the cancel.
- R11: A zero-length request is accepted, issues no store, and reads done right away without raising its hazard flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq | input | 1 | Interrupt indication, deliberately ignored |
| req_valid | input | 1 | New block-fill request |
| req_base | input | AW | First word address |
| req_len | input | LW | Number of words to write |
| req_value | input | DW | Word written to every address |
| req_ready | output | 1 | A buffer is free |
| req_handle | output | HW | Handle given to the request |
| qry_valid | input | 1 | Status read; frees a finished buffer |
| qry_handle | input | HW | Buffer being queried |
| qry_status | output | 2 | State of the queried buffer |
| cxl_valid | input | 1 | Cancel request |
| cxl_handle | input | HW | Buffer to cancel |
| mem_busy | input | 1 | Memory unit busy with foreground work |
| mem_we | output | 1 | Store strobe |
| mem_addr | output | AW | Store address |
| mem_data | output | DW | Store data |
| hazard | output | NBUF | Per-buffer in-flight flag |

## Verification
A wrong slot state shows at the ports within one cycle. A lost remaining-count or address step shows up as a missing, extra or misplaced word in the memory image as soon as the buffer finishes, and the sentinel word just past each range catches a store that runs over. A wrong round-robin pointer changes the interleaved address order on the first cycle that two buffers compete. Bad cancel or release handling shows as a wrong status code on the next query, or as stores that keep arriving after the cancel edge.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic [1:0] {
      ST_FREE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2,
      ST_CANC = 2'd3
   } bgs_state_e;
endpackage

// File: rtl/bgs_slot.sv
module bgs_slot
   import bgs_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 16,
   parameter int LW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          alloc,
   input  logic [AW-1:0] base,
   input  logic [LW-1:0] len,
   input  logic [DW-1:0] value,
   input  logic          grant,
   input  logic          cancel,
   input  logic          release_i,
   output bgs_state_e    state,
   output logic [AW-1:0] addr,
   output logic [DW-1:0] data,
   output logic          active
);
   localparam logic [LW-1:0] ONE = LW'(1);

   bgs_state_e    st_q;
   logic [AW-1:0] addr_q;
   logic [LW-1:0] left_q;
   logic [DW-1:0] data_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_FREE;
         addr_q <= '0;
         left_q <= '0;
         data_q <= '0;
      end else begin
         unique case (st_q)
            ST_FREE: if (alloc) begin
               st_q   <= (len == '0) ? ST_DONE : ST_RUN;
               addr_q <= base;
               left_q <= len;
               data_q <= value;
            end
            ST_RUN: begin
               if (grant) begin
                  addr_q <= addr_q + AW'(1);
                  left_q <= left_q - ONE;
               end
               if (grant && left_q == ONE) st_q <= ST_DONE;
               else if (cancel)           st_q <= ST_CANC;
            end
            default: if (release_i) st_q <= ST_FREE;
         endcase
      end
   end

   assign state  = st_q;
   assign addr   = addr_q;
   assign data   = data_q;
   assign active = (st_q == ST_RUN);
endmodule

// File: rtl/bgs_rr_arb.sv
module bgs_rr_arb #(
   parameter int N  = 4,
   parameter int HW = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [HW-1:0] last_q;
   logic [HW-1:0] pick;
   logic          found;

   always_comb begin
      grant = '0;
      pick  = '0;
      found = 1'b0;
      for (int k = 1; k <= N; k++) begin
         int j;
         j = (int'(last_q) + k) % N;
         if (!found && req[j]) begin
            found    = 1'b1;
            pick     = HW'(j);
            grant[j] = en;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)            last_q <= HW'(N - 1);
      else if (en && found)  last_q <= pick;
   end
endmodule

// File: rtl/bgs_engine.sv
module bgs_engine
   import bgs_pkg::*;
#(
   parameter int NBUF = 4,
   parameter int AW   = 16,
   parameter int DW   = 16,
   parameter int LW   = 8,
   parameter int HW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq,
   input  logic            req_valid,
   input  logic [AW-1:0]   req_base,
   input  logic [LW-1:0]   req_len,
   input  logic [DW-1:0]   req_value,
   output logic            req_ready,
   output logic [HW-1:0]   req_handle,
   input  logic            qry_valid,
   input  logic [HW-1:0]   qry_handle,
   output logic [1:0]      qry_status,
   input  logic            cxl_valid,
   input  logic [HW-1:0]   cxl_handle,
   input  logic            mem_busy,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_data,
   output logic [NBUF-1:0] hazard
);
   if (NBUF < 2 || (1 << HW) != NBUF) begin : g_bad_nbuf
      $error("bgs_engine: NBUF must be a power of two of at least 2");
   end
   if (AW < 1 || DW < 1 || LW < 1) begin : g_bad_width
      $error("bgs_engine: widths must be positive");
   end

   bgs_state_e    s_state [NBUF];
   logic [AW-1:0] s_addr  [NBUF];
   logic [DW-1:0] s_data  [NBUF];
   logic [NBUF-1:0] s_act, s_free, s_alloc, s_cancel, s_release, s_grant;
   logic          accept;
   logic          irq_unused;

   assign irq_unused = irq;
   assign accept     = req_valid && req_ready;

   always_comb begin
      req_handle = '0;
      for (int i = NBUF - 1; i >= 0; i--)
         if (s_free[i]) req_handle = HW'(i);
   end
   assign req_ready = |s_free;

   for (genvar g = 0; g < NBUF; g++) begin : g_slot
      assign s_free[g]    = (s_state[g] == ST_FREE);
      assign s_alloc[g]   = accept && (req_handle == HW'(g));
      assign s_cancel[g]  = cxl_valid && (cxl_handle == HW'(g));
      assign s_release[g] = qry_valid && (qry_handle == HW'(g)) &&
                            (s_state[g] == ST_DONE || s_state[g] == ST_CANC);
      bgs_slot #(.AW(AW), .DW(DW), .LW(LW)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .alloc     (s_alloc[g]),
         .base      (req_base),
         .len       (req_len),
         .value     (req_value),
         .grant     (s_grant[g]),
         .cancel    (s_cancel[g]),
         .release_i (s_release[g]),
         .state     (s_state[g]),
         .addr      (s_addr[g]),
         .data      (s_data[g]),
         .active    (s_act[g])
      );
   end

   bgs_rr_arb #(.N(NBUF), .HW(HW)) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (!mem_busy),
      .req   (s_act),
      .grant (s_grant)
   );

   always_comb begin
      mem_addr = '0;
      mem_data = '0;
      for (int i = 0; i < NBUF; i++) begin
         if (s_grant[i]) begin
            mem_addr = mem_addr | s_addr[i];
            mem_data = mem_data | s_data[i];
         end
      end
   end

   assign mem_we     = |s_grant;
   assign qry_status = s_state[qry_handle];
   assign hazard     = s_act;
endmodule

// File: rtl/bgs_checker.sv
module bgs_checker #(
   parameter int NBUF = 4,
   parameter int LW   = 8,
   parameter int HW   = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic [HW-1:0]   req_handle,
   input logic [LW-1:0]   req_len,
   input logic            cxl_valid,
   input logic [HW-1:0]   cxl_handle,
   input logic            mem_busy,
   input logic            mem_we,
   input logic [NBUF-1:0] hazard
);
   AST_NO_STORE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_busy |-> !mem_we); // R2
   AST_STORE_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (hazard != '0)); // R10
   AST_ACCEPT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_len != '0) |=> hazard[$past(req_handle)]); // R10
   AST_ZERO_LEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_len == '0) |=> !hazard[$past(req_handle)]); // R11
   AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cxl_valid && hazard[cxl_handle]) |=> !hazard[$past(cxl_handle)]); // R5
endmodule

bind bgs_engine bgs_checker #(.NBUF(NBUF), .LW(LW), .HW(HW)) u_bgs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_handle (req_handle),
   .req_len    (req_len),
   .cxl_valid  (cxl_valid),
   .cxl_handle (cxl_handle),
   .mem_busy   (mem_busy),
   .mem_we     (mem_we),
   .hazard     (hazard)
);

// File: tb/bgs_engine_test.sv
`timescale 1ns/1ps
module bgs_engine_test;
   localparam int NBUF = 4;
   localparam int AW   = 8;
   localparam int DW   = 16;
   localparam int LW   = 6;
   localparam int HW   = 2;
   localparam logic [DW-1:0] SENT = 16'hDEAD;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic irq = 1'b0;
   logic req_valid = 1'b0;
   logic [AW-1:0] req_base = '0;
   logic [LW-1:0] req_len = '0;
   logic [DW-1:0] req_value = '0;
   logic req_ready;
   logic [HW-1:0] req_handle;
   logic qry_valid = 1'b0;
   logic [HW-1:0] qry_handle = '0;
   logic [1:0] qry_status;
   logic cxl_valid = 1'b0;
   logic [HW-1:0] cxl_handle = '0;
   logic mem_busy = 1'b0;
   logic mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data;
   logic [NBUF-1:0] hazard;

   always #5 clk = ~clk;

   bgs_engine #(.NBUF(NBUF), .AW(AW), .DW(DW), .LW(LW), .HW(HW)) uut (.*);

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [256];
   logic [AW-1:0] log_a [1024];
   int nlog = 0;
   int cyc = 0;
   int busy_mode = 0;
   logic busy_force = 1'b0;
   logic irq_toggle = 1'b0;

   always @(posedge clk) begin
      if (rst_n && mem_we) begin
         model[mem_addr] = mem_data;
         if (nlog < 1024) log_a[nlog] = mem_addr;
         nlog++;
      end
   end

   always @(negedge clk) begin
      cyc++;
      mem_busy = busy_force || (busy_mode == 1 && cyc[0]) || (busy_mode == 2 && (cyc % 3) != 0);
      irq = irq_toggle ? ~irq : 1'b0;
   end

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic do_req(input logic [AW-1:0] b, input logic [LW-1:0] l,
                         input logic [DW-1:0] v, output logic ok, output logic [HW-1:0] h);
      req_base = b; req_len = l; req_value = v; req_valid = 1'b1;
      #1;
      ok = req_ready; h = req_handle;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic query(input logic [HW-1:0] h, output logic [1:0] s);
      qry_handle = h; qry_valid = 1'b1;
      #1;
      s = qry_status;
      @(posedge clk);
      @(negedge clk);
      qry_valid = 1'b0;
   endtask

   task automatic cancel(input logic [HW-1:0] h);
      cxl_handle = h; cxl_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cxl_valid = 1'b0;
   endtask

   task automatic wait_idle(input logic [NBUF-1:0] m, input string tag);
      int n = 0;
      while ((hazard & m) != '0 && n < 400) begin
         @(negedge clk);
         n++;
      end
      chk(n < 400, tag, n, 0);
   endtask

   initial begin : watchdog
      #1500000;
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main
      logic ok;
      logic [HW-1:0] h, h0, h1;
      logic [1:0] s;
      int n0;
      for (int i = 0; i < 256; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(req_ready === 1'b1, "R1 reset ready", int'(req_ready), 1);
      chk(req_handle === '0, "R1 reset handle", int'(req_handle), 0);
      chk(hazard === '0, "R10 reset hazard", int'(hazard), 0);
      chk(mem_we === 1'b0, "R2 reset no store", int'(mem_we), 0);
      @(negedge clk);

      // R2/R3: first store in the cycle after accept
      n0 = nlog;
      do_req(8'h10, 6'd3, 16'h1234, ok, h);
      chk(ok && h == 0, "R1 accept handle", int'(h), 0);
      #1;
      chk(mem_we && mem_addr == 8'h10 && mem_data == 16'h1234, "R2 first store timing", int'(mem_addr), 'h10);
      chk(hazard[0] == 1'b1, "R10 hazard raised", int'(hazard), 1);
      wait_idle(4'b0001, "R3 finish");
      chk(nlog - n0 == 3, "R3 store count", nlog - n0, 3);
      query(h, s);
      chk(s == 2'd2, "R7 done code", int'(s), 2);
      query(h, s);
      chk(s == 2'd0, "R8 freed after read", int'(s), 0);

      // R4: round robin between two buffers
      n0 = nlog;
      do_req(8'h10, 6'd3, 16'h0A0A, ok, h0);
      do_req(8'h40, 6'd3, 16'h0B0B, ok, h1);
      chk(h0 == 0 && h1 == 1, "R1 lowest free handles", int'(h1), 1);
      wait_idle(4'b0011, "R4 finish");
      begin
         logic [AW-1:0] exp_seq [6];
         exp_seq = '{8'h10, 8'h40, 8'h11, 8'h41, 8'h12, 8'h42};
         for (int i = 0; i < 6; i++)
            chk(log_a[n0 + i] == exp_seq[i], "R4 round-robin order", int'(log_a[n0 + i]), int'(exp_seq[i]));
      end
      query(h0, s); query(h1, s);

      // R5: cancel mid-run, store in cancel cycle commits
      n0 = nlog;
      do_req(8'h80, 6'd10, 16'h5555, ok, h);
      cancel(h);
      repeat (5) @(negedge clk);
      chk(nlog - n0 == 1, "R5 stores after cancel", nlog - n0, 1);
      query(h, s);
      chk(s == 2'd3, "R5 cancelled code", int'(s), 3);
      query(h, s);
      chk(s == 2'd0, "R8 cancelled freed", int'(s), 0);

      // R6: cancel on the final store
      n0 = nlog;
      do_req(8'h90, 6'd1, 16'h6666, ok, h);
      cancel(h);
      query(h, s);
      chk(s == 2'd2 && nlog - n0 == 1, "R6 final store wins", int'(s), 2);

      // R5: cancel while memory busy, no stores
      busy_force = 1'b1;
      @(negedge clk);
      n0 = nlog;
      do_req(8'hA0, 6'd4, 16'h7777, ok, h);
      cancel(h);
      busy_force = 1'b0;
      repeat (6) @(negedge clk);
      chk(nlog == n0, "R5 busy cancel no stores", nlog - n0, 0);
      query(h, s);
      chk(s == 2'd3, "R5 busy cancel code", int'(s), 3);
      cancel(h);
      query(h, s);
      chk(s == 2'd0, "R5 cancel of free ignored", int'(s), 0);

      // R1/R8: fill all buffers, refuse fifth
      busy_force = 1'b1;
      @(negedge clk);
      n0 = nlog;
      for (int i = 0; i < NBUF; i++) begin
         do_req(AW'(8'hB0 + 4 * i), 6'd2, DW'(i), ok, h);
         chk(ok && h == HW'(i), "R1 fill handles", int'(h), i);
      end
      do_req(8'hF0, 6'd2, 16'h0, ok, h);
      chk(!ok, "R1 refused when full", int'(ok), 0);
      chk(hazard == 4'hF && nlog == n0, "R2 held by busy", int'(hazard), 15);
      query(2'd2, s);
      query(2'd2, s);
      chk(s == 2'd1, "R8 running not freed", int'(s), 1);
      busy_force = 1'b0;
      wait_idle(4'hF, "R1 full drain");
      for (int i = 0; i < NBUF; i++) begin
         query(HW'(i), s);
         chk(s == 2'd2, "R7 drained done", int'(s), 2);
      end
      #1;
      chk(req_ready, "R8 ready after release", int'(req_ready), 1);
      chk(nlog - n0 == 8, "R3 full drain count", nlog - n0, 8);

      // R11: zero length
      n0 = nlog;
      do_req(8'hC8, 6'd0, 16'h9999, ok, h);
      #1;
      chk(hazard == '0, "R11 no hazard", int'(hazard), 0);
      query(h, s);
      chk(s == 2'd2 && nlog == n0, "R11 done no store", int'(s), 2);

      // R3/R9: sweep lengths and busy patterns with irq toggling
      irq_toggle = 1'b1;
      for (int l = 1; l <= 8; l++) begin
         for (int m = 0; m < 3; m++) begin
            logic [AW-1:0] b;
            logic [DW-1:0] v;
            b = AW'(l * 24 + m);
            v = DW'(l * 7 + m * 100);
            model[b + AW'(l)] = SENT;
            busy_mode = m;
            n0 = nlog;
            do_req(b, LW'(l), v, ok, h);
            wait_idle(4'hF, "R9 sweep finish");
            busy_mode = 0;
            chk(nlog - n0 == l, "R9 sweep count", nlog - n0, l);
            for (int k = 0; k < l; k++)
               chk(model[b + AW'(k)] == v, "R3 sweep data", int'(model[b + AW'(k)]), int'(v));
            chk(model[b + AW'(l)] == SENT, "R3 no overrun", int'(model[b + AW'(l)]), int'(SENT));
            query(h, s);
            chk(s == 2'd2, "R9 sweep done", int'(s), 2);
         end
      end
      irq_toggle = 1'b0;

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule